// File: doc/BRIEF.md
# High-Window DRAM Remap Translator

This block sits in the address path of a memory controller. It translates host physical addresses so that DRAM hidden behind the MMIO hole below 4 GiB can still be reached. The shadowed DRAM is instead reached through a window placed above 4 GiB. Software writes three configuration values through a plain strobe port:

- the low-memory ceiling (the remap source base);
- a packed control word that holds an enable bit and the window's lower and upper bounds;
- the installed DRAM size.

Every window boundary moves in 64 MiB steps. Only address bits [33:26] therefore take part in window matching and offset arithmetic, and bits [25:0] always pass through unchanged.

Host addresses enter on a valid/ready stream and leave on a second valid/ready stream one register stage later. Each result carries the DRAM address and a hit flag. A downstream stall holds the result in place. The input is accepted only when the output register is empty or is being drained in the same cycle, so back-pressure reaches the source with no added buffering.

Software normally places the window bottom at 4 GiB when DRAM ends below 4 GiB, and at the DRAM top otherwise. The window size is then the shadowed amount: DRAM top minus source base, or 4 GiB minus source base, respectively.

Top module: `remap_xlate`

## Requirements
- R1: A configuration write is sampled on the rising edge where `cfg_we` is high. Selector 0 loads the source base from `cfg_wdata[15:4]` in 1 MiB units, with its six low bits forced to zero. Selector 1 loads the control word from `cfg_wdata[31:0]`. Selector 2 loads the DRAM top from `cfg_wdata[10:0]`. An address accepted on that same edge is translated with the previous settings.
- R2: With control bit 0 clear, no address is translated, and `out_addr` equals the input address.
- R3: With control bit 0 set, let `to` be control bits [11:2] and `until` be control bits [23:14], both in 64 MiB units. If `to <= A[33:26] < until`, the result is source_base + (A - to × 64 MiB) with hit = 1.
- R4: When `until <= to`, the window is empty. No address is translated, even with bit 0 set.
- R5: An address in [source_base, 4 GiB) that is not a window hit yields hit = 0, and the address passes through unchanged.
- R6: Any other address passes through unchanged. Its hit is 1 only when it lies below the DRAM top, which is the 11-bit value in 16 MiB units (top = value × 2^24).
- R7: `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_hit` hold.
- R8: An address accepted on one rising edge appears on the output after that same edge. Results leave in acceptance order.
- R9: After reset, `out_valid` is low, `in_ready` is high, and all three configuration values are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 source base, 1 control word, 2 DRAM top |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Host address valid |
| in_ready | output | 1 | Translator can accept an address |
| in_addr | input | 34 | Host physical address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_addr | output | 34 | DRAM address |
| out_hit | output | 1 | Address maps to DRAM |

## Verification
Two events can land on the same edge: a configuration write and the acceptance of a host address. The bench drains the pipeline and then raises `cfg_we` and `in_valid` together. It expects the result to follow the settings that were in force before the write, and the next address to follow the new ones. Output stalls are a second collision: the consumer drops `out_ready` on a pseudo-random pattern while addresses keep arriving. The scoreboard confirms that no result is lost, duplicated or altered.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_CTRL  = 2'd1,
    CFG_TOP   = 2'd2,
    CFG_SPARE = 2'd3
  } cfg_target_e;

  // Position of the enable bit inside the control word.
  localparam int unsigned CTRL_EN_BIT = 0;

endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int unsigned BASE_W   = 12,
  parameter int unsigned BASE_LSB = 4,
  parameter int unsigned ALIGN_W  = 6,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned TOP_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [BASE_W-1:0] base_mib,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [TOP_W-1:0]  top_val
);

  localparam logic [BASE_W-1:0] ALIGN_MASK = ~(BASE_W'((1 << ALIGN_W) - 1));

  cfg_target_e target;
  assign target = cfg_target_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_mib  <= '0;
      ctrl_word <= '0;
      top_val   <= '0;
    end else if (cfg_we) begin
      unique case (target)
        CFG_BASE:  base_mib  <= cfg_wdata[BASE_LSB +: BASE_W] & ALIGN_MASK;
        CFG_CTRL:  ctrl_word <= cfg_wdata;
        CFG_TOP:   top_val   <= cfg_wdata[TOP_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/remap_window_decode.sv
module remap_window_decode
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 34,
  parameter int unsigned GRAN_SH = 26,
  parameter int unsigned BASE_W  = 12,
  parameter int unsigned ALIGN_W = 6,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned FIELD_W = 10,
  parameter int unsigned TO_LSB  = 2,
  parameter int unsigned UNT_LSB = 14,
  parameter int unsigned TOP_W   = 11,
  parameter int unsigned TOP_SH  = 24,
  parameter int unsigned HOLE_SH = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base_mib,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [TOP_W-1:0]  top_val,
  output logic [ADDR_W-1:0] xaddr,
  output logic              hit
);

  localparam int unsigned UNIT_W  = ADDR_W - GRAN_SH;
  localparam int unsigned BUNIT_W = BASE_W - ALIGN_W;
  localparam int unsigned TB_W    = TOP_W + TOP_SH;
  localparam int unsigned HB_W    = ADDR_W + 1;
  localparam logic [HB_W-1:0] HOLE_END = HB_W'(1) << HOLE_SH;

  logic [FIELD_W-1:0] a_unit, to_unit, until_unit, base_unit, off_unit, dest_unit;
  logic               enable, win_nonempty, in_window;
  logic [HB_W-1:0]    addr_ext, base_byte;
  logic [TB_W-1:0]    top_byte, addr_top;
  logic               in_hole, below_top;

  assign enable     = ctrl_word[CTRL_EN_BIT];
  assign to_unit    = ctrl_word[TO_LSB  +: FIELD_W];
  assign until_unit = ctrl_word[UNT_LSB +: FIELD_W];
  assign a_unit     = FIELD_W'(addr[ADDR_W-1:GRAN_SH]);
  assign base_unit  = FIELD_W'(base_mib[BASE_W-1:ALIGN_W]);

  assign win_nonempty = until_unit > to_unit;
  assign in_window    = enable && win_nonempty &&
                        (a_unit >= to_unit) && (a_unit < until_unit);

  assign off_unit  = a_unit - to_unit;
  assign dest_unit = base_unit + off_unit;

  assign addr_ext  = HB_W'(addr);
  assign base_byte = HB_W'(base_mib[BASE_W-1:ALIGN_W]) << GRAN_SH;
  assign in_hole   = (addr_ext >= base_byte) && (addr_ext < HOLE_END);

  assign top_byte  = {top_val, {TOP_SH{1'b0}}};
  assign addr_top  = TB_W'(addr);
  assign below_top = addr_top < top_byte;

  always_comb begin
    if (in_window) begin
      xaddr = {dest_unit[UNIT_W-1:0], addr[GRAN_SH-1:0]};
      hit   = 1'b1;
    end else if (in_hole) begin
      xaddr = addr;
      hit   = 1'b0;
    end else begin
      xaddr = addr;
      hit   = below_top;
    end
  end

endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage #(
  parameter int unsigned DATA_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_addr,
  input  logic              s_hit,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_addr,
  output logic              m_hit
);

  logic take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_addr <= '0;
      m_hit  <= 1'b0;
    end else if (take) begin
      m_addr <= s_addr;
      m_hit  <= s_hit;
    end
  end

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 34,
  parameter int unsigned GRAN_SH  = 26,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned BASE_W   = 12,
  parameter int unsigned BASE_LSB = 4,
  parameter int unsigned FIELD_W  = 10,
  parameter int unsigned TO_LSB   = 2,
  parameter int unsigned UNT_LSB  = 14,
  parameter int unsigned TOP_W    = 11,
  parameter int unsigned TOP_SH   = 24,
  parameter int unsigned HOLE_SH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hit
);

  // Base is held in 1 MiB units; alignment bits follow from the granule.
  localparam int unsigned ALIGN_W = GRAN_SH - 20;

  logic [BASE_W-1:0] base_mib;
  logic [CTRL_W-1:0] ctrl_word;
  logic [TOP_W-1:0]  top_val;
  logic [ADDR_W-1:0] xaddr;
  logic              xhit;

  remap_cfg_regs #(
    .BASE_W  (BASE_W),
    .BASE_LSB(BASE_LSB),
    .ALIGN_W (ALIGN_W),
    .CTRL_W  (CTRL_W),
    .TOP_W   (TOP_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .base_mib (base_mib),
    .ctrl_word(ctrl_word),
    .top_val  (top_val)
  );

  remap_window_decode #(
    .ADDR_W (ADDR_W),
    .GRAN_SH(GRAN_SH),
    .BASE_W (BASE_W),
    .ALIGN_W(ALIGN_W),
    .CTRL_W (CTRL_W),
    .FIELD_W(FIELD_W),
    .TO_LSB (TO_LSB),
    .UNT_LSB(UNT_LSB),
    .TOP_W  (TOP_W),
    .TOP_SH (TOP_SH),
    .HOLE_SH(HOLE_SH)
  ) u_dec (
    .addr     (in_addr),
    .base_mib (base_mib),
    .ctrl_word(ctrl_word),
    .top_val  (top_val),
    .xaddr    (xaddr),
    .hit      (xhit)
  );

  remap_out_stage #(
    .DATA_W(ADDR_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_addr (xaddr),
    .s_hit  (xhit),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_addr (out_addr),
    .m_hit  (out_hit)
  );

endmodule

// File: rtl/remap_xlate_chk.sv
module remap_xlate_chk #(
  parameter int unsigned ADDR_W  = 34,
  parameter int unsigned GRAN_SH = 26,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned BASE_W  = 12,
  parameter int unsigned HOLE_SH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_hit,
  input logic [BASE_W-1:0] base_mib,
  input logic [CTRL_W-1:0] ctrl_word
);

  localparam int unsigned HB_W = ADDR_W + 1;

  logic            accept;
  logic [HB_W-1:0] base_b, addr_b;
  logic            empty_win;

  assign accept    = in_valid && in_ready;
  assign base_b    = HB_W'(base_mib) << (GRAN_SH - 6);
  assign addr_b    = HB_W'(in_addr);
  assign empty_win = ctrl_word[23:14] <= ctrl_word[11:2];

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_hit));

  // R7
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R5
  hole_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ctrl_word[0] && addr_b >= base_b && addr_b < (HB_W'(1) << HOLE_SH)
    |=> !out_hit && out_addr == $past(in_addr));

  // R4
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && empty_win |=> out_addr == $past(in_addr));

endmodule

bind remap_xlate remap_xlate_chk #(
  .ADDR_W (ADDR_W),
  .GRAN_SH(GRAN_SH),
  .CTRL_W (CTRL_W),
  .BASE_W (BASE_W),
  .HOLE_SH(HOLE_SH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_addr  (in_addr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_hit  (out_hit),
  .base_mib (base_mib),
  .ctrl_word(ctrl_word)
);

// File: tb/remap_xlate_bench.sv
`timescale 1ns/1ps
module remap_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [33:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [33:0] out_addr;
  logic        out_hit;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [33:0] q_addr[$];
  logic        q_hit[$];
  string       q_tag[$];

  bit        force_ready = 1'b0;
  bit        hold_ready  = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // Bench-side copy of the configuration, updated from the requirements.
  logic [11:0] m_base = '0;
  logic [31:0] m_ctrl = '0;
  logic [10:0] m_top  = '0;

  always #4 clk = ~clk;

  remap_xlate u_remap_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_hit(out_hit)
  );

  function automatic void model(input logic [33:0] a, output logic [33:0] xa,
                                output logic hit);
    logic [9:0]  au, tu, uu, bu, du;
    logic [34:0] aext;
    au = {2'b00, a[33:26]};
    tu = m_ctrl[11:2];
    uu = m_ctrl[23:14];
    bu = {4'b0, m_base[11:6]};
    aext = {1'b0, a};
    if (m_ctrl[0] && uu > tu && au >= tu && au < uu) begin
      du = bu + (au - tu);
      xa = {du[7:0], a[25:0]};
      hit = 1'b1;
    end else if (aext >= ({29'b0, m_base[11:6]} << 26) && aext < (35'd1 << 32)) begin
      xa = a; hit = 1'b0;
    end else begin
      xa = a; hit = aext < {m_top, 24'b0};
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
    case (sel)
      2'd0: m_base = d[15:4] & 12'hFC0;
      2'd1: m_ctrl = d;
      2'd2: m_top  = d[10:0];
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(sel, d);
  endtask

  task automatic push_exp(input logic [33:0] a, input string tag);
    logic [33:0] xa;
    logic h;
    model(a, xa, h);
    q_addr.push_back(xa);
    q_hit.push_back(h);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [33:0] a, input string tag);
    bit done;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    done = 1'b0;
    while (!done) begin
      #1;
      if (in_ready) begin
        push_exp(a, tag);
        done = 1'b1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_addr.size() != 0 || out_valid) @(negedge clk);
  endtask

  // Monitor: owns out_ready; pops one expectation per completed transfer.
  always @(negedge clk) begin
    bit r;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    r = hold_ready ? 1'b0 : (force_ready ? 1'b1 : lfsr[0] | lfsr[2]);
    out_ready = r;
    if (rst_n && out_valid && r) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R8", "unexpected result", {30'b0, out_addr}, 64'd0);
      end else begin
        logic [33:0] ea;
        logic eh;
        string t;
        ea = q_addr.pop_front();
        eh = q_hit.pop_front();
        t  = q_tag.pop_front();
        check(out_addr == ea, t, "out_addr", {30'b0, out_addr}, {30'b0, ea});
        check(out_hit == eh, t, "out_hit", {63'b0, out_hit}, {63'b0, eh});
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", "out_valid after reset", {63'b0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", {63'b0, in_ready}, 64'd1);
    rst_n = 1'b1;
    // R9 cleared configuration: base 0 makes all low space a hole, top 0 misses above
    send(34'h0_1234_5678, "R9");
    send(34'h1_0000_0040, "R9");
    drain();

    // Base 3 GiB written with junk in low MiB bits (R1 masking), top 3.5 GiB.
    cfg_write(2'd0, 32'h0000_C3F0);
    cfg_write(2'd2, 32'd224);
    cfg_write(2'd1, (32'd64 << 2) | (32'd72 << 14) | 32'd1);
    send(34'h1_0000_0000, "R3");
    send(34'h1_1000_1234, "R3");
    send(34'h1_2000_0000, "R6");
    send(34'h0_BFFF_FFFC, "R6");
    send(34'h0_C000_0000, "R5");
    send(34'h0_FFFF_FFFF, "R5");
    send(34'h0_C3F0_0000, "R1");

    // DRAM above 4 GiB: top 6 GiB, window starts at the top.
    cfg_write(2'd2, 32'd384);
    cfg_write(2'd1, (32'd96 << 2) | (32'd112 << 14) | 32'd1);
    send(34'h1_4000_0000, "R6");
    send(34'h1_8000_0010, "R3");
    send(34'h1_BFFF_FFFF, "R3");
    send(34'h1_C000_0000, "R6");
    send(34'h3_FFFF_FFFF, "R6");

    // R2 disable bit clear
    cfg_write(2'd1, (32'd96 << 2) | (32'd112 << 14));
    send(34'h1_8000_0010, "R2");
    send(34'h0_D000_0000, "R2");
    // R4 empty window with enable set
    cfg_write(2'd1, (32'd96 << 2) | (32'd96 << 14) | 32'd1);
    send(34'h1_8000_0010, "R4");
    cfg_write(2'd1, (32'd100 << 2) | (32'd96 << 14) | 32'd1);
    send(34'h1_9000_0000, "R4");
    drain();

    // R1 concurrency: write and accept on the same edge uses old settings.
    force_ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1;
    cfg_wdata = (32'd96 << 2) | (32'd112 << 14) | 32'd1;
    in_valid = 1'b1; in_addr = 34'h1_8000_0020;
    #1;
    check(in_ready == 1'b1, "R1", "in_ready in collision", {63'b0, in_ready}, 64'd1);
    push_exp(34'h1_8000_0020, "R1");
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    model_write(2'd1, (32'd96 << 2) | (32'd112 << 14) | 32'd1);
    send(34'h1_8000_0020, "R1");
    drain();

    // R7/R8 stall: hold the result and check it stays put.
    hold_ready = 1'b1;
    send(34'h1_8000_0100, "R7");
    @(negedge clk);
    begin
      logic [33:0] held;
      held = out_addr;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1, "R7", "out_valid held", {63'b0, out_valid}, 64'd1);
      check(out_addr == held, "R7", "out_addr held", {30'b0, out_addr}, {30'b0, held});
      check(in_ready == 1'b0, "R7", "in_ready during stall", {63'b0, in_ready}, 64'd0);
    end
    hold_ready = 1'b0;
    force_ready = 1'b0;
    drain();

    // R8 ordering under random back-pressure.
    for (int i = 0; i < 40; i++) begin
      send({2'(i % 4), 6'(i * 5), 26'(i * 977)}, "R8");
    end
    drain();
    check(q_addr.size() == 0, "R8", "scoreboard empty", 64'(q_addr.size()), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule